// File: doc/BRIEF.md
# PCIe Root-Port Link Bring-up Sequencer

This block is a small hardware master on a simple register bus. After a start pulse it takes a PCIe root-port controller from its reset state to a trained link. It then opens the outbound window used for configuration accesses, with no software involved. Every controller access is one request/acknowledge transaction. Bit-field updates are done as a read followed by a write, so that bits the sequencer does not own keep their values.

The order of operations is as follows:

1. Sample the link status. If the link is down, pause link training.
2. Select root-complex mode and write the bus-master cache attributes.
3. Program the target link speed and the equalization option.
4. Restart training if the link is still down.
5. Poll the status until the link comes up or the timeout expires.
6. After link-up, wait a settle interval.
7. Capture the negotiated speed and width.
8. Program translation region 0 as a config-type window.

The outcome is reported on `done` and `link_ok`. The timeout and the settle interval are given in milliseconds and microseconds and converted to cycles from the `CLK_HZ` parameter.

Top module: `pcie_link_seq`

## Requirements
- R1: While reset is held and after its release, `done`, `link_ok`, `bus_req`, `link_speed` and `link_width` are all 0.
- R2: The link counts as up only when bit 1 and bit 9 of the status register at 0x8008 are both 1. With either bit alone, the run ends in failure.
- R3: If the first status read shows the link down, the first write of the run goes to the control register at 0x8000. That write is the read value with bit 2 (training enable) cleared. If the link is already up, bit 2 of every control write keeps the value read.
- R4: The root-complex write to 0x8000 puts 4 into bits 7:4 and preserves every other bit.
- R5: The value 0x3511 is written to 0x8050, and the value 0x5311 is written to 0x8054.
- R6: The low 4 bits of 0xA0 and of 0x7C are set to `TGT_SPEED`, and bit 5 of 0x8A8 is set. All other bits of these registers are preserved.
- R7: A second control write that sets bit 2 is issued only when a status read after configuration still shows the link down.
- R8: If the link is not up within the timeout (`LINK_TMO_MS` ms of `CLK_HZ` cycles), the run ends with `done`=1 and `link_ok`=0. No window registers are written in that case.
- R9: At least `SETTLE_US` µs of cycles pass between the first status read that shows link-up and the read of 0x80.
- R10: The window writes are, in order: 0x900=0, 0x90C=`cfg_base`, 0x910=0, 0x914=`cfg_base`+`cfg_size`, 0x918=0, 0x91C=0, 0x904=4, 0x908=0x80000000.
- R11: On success, `done`=1 and `link_ok`=1. `link_speed` holds bits 19:16 and `link_width` holds bits 23:20 of the register at 0x80. Both values are held until the next success.
- R12: Once `bus_req` is raised, it and its address, data and direction stay stable until `bus_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a run when idle or finished |
| cfg_base | input | 32 | Base address of the config window |
| cfg_size | input | 32 | Size of the config window |
| bus_req | output | 1 | Register transaction request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Register address |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Transaction completed |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |
| done | output | 1 | Run finished |
| link_ok | output | 1 | Run finished with the link up |
| link_speed | output | 4 | Captured link speed |
| link_width | output | 4 | Captured link width |

## Verification
The bench builds the block with `CLK_HZ` = 100000, which gives a 10000-cycle link timeout and a 10-cycle settle interval. At this setting the failure path is reached within the run budget, and so is the measured gap between link-up and the speed read. The register model behind the bus covers three cases: a link that is down at start and trains some tens of cycles after training is re-enabled, a link that is up from the beginning, and a link that reports only one of the two up bits. These cases exercise both skip decisions, the read-modify-write masks and the timeout exit.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

    localparam logic [31:0] RA_GCTRL  = 32'h0000_8000;
    localparam logic [31:0] RA_GSTAT  = 32'h0000_8008;
    localparam logic [31:0] RA_RCACHE = 32'h0000_8050;
    localparam logic [31:0] RA_WCACHE = 32'h0000_8054;
    localparam logic [31:0] RA_LSTAT  = 32'h0000_0080;
    localparam logic [31:0] RA_LCTL2  = 32'h0000_00A0;
    localparam logic [31:0] RA_LCAP   = 32'h0000_007C;
    localparam logic [31:0] RA_EQCTL  = 32'h0000_08A8;
    localparam logic [31:0] RA_WSEL   = 32'h0000_0900;
    localparam logic [31:0] RA_WCR1   = 32'h0000_0904;
    localparam logic [31:0] RA_WCR2   = 32'h0000_0908;
    localparam logic [31:0] RA_WBLO   = 32'h0000_090C;
    localparam logic [31:0] RA_WBHI   = 32'h0000_0910;
    localparam logic [31:0] RA_WLIM   = 32'h0000_0914;
    localparam logic [31:0] RA_WTLO   = 32'h0000_0918;
    localparam logic [31:0] RA_WTHI   = 32'h0000_091C;

    localparam logic [31:0] TRAIN_EN   = 32'h0000_0004;
    localparam logic [31:0] MODE_MASK  = 32'h0000_00F0;
    localparam logic [31:0] MODE_RC    = 32'h0000_0040;
    localparam logic [31:0] RCACHE_VAL = 32'h0000_3511;
    localparam logic [31:0] WCACHE_VAL = 32'h0000_5311;
    localparam logic [31:0] EQ_OPT     = 32'h0000_0020;
    localparam logic [31:0] WIN_CFG0   = 32'h0000_0004;
    localparam logic [31:0] WIN_ON     = 32'h8000_0000;

    typedef enum logic [4:0] {
        S_IDLE, S_CHK0, S_CTL_RD, S_HALT, S_TYPE, S_RCACHE, S_WCACHE,
        S_LC2_RD, S_LC2_WR, S_CAP_RD, S_CAP_WR, S_EQ_RD, S_EQ_WR,
        S_CHK1, S_RUN_RD, S_RUN_WR, S_POLL, S_SETTLE, S_LSTAT,
        S_W_SEL, S_W_BLO, S_W_BHI, S_W_LIM, S_W_TLO, S_W_THI,
        S_W_CR1, S_W_CR2, S_OK, S_FAIL
    } step_t;

    typedef struct packed {
        logic        vld;
        logic        we;
        logic [31:0] addr;
        logic [31:0] data;
    } bus_op_t;

    function automatic logic link_is_up(input logic [31:0] sts);
        return sts[1] & sts[9];
    endfunction

    function automatic logic [31:0] merge_field(input logic [31:0] old,
                                                input logic [31:0] mask,
                                                input logic [31:0] val);
        return (old & ~mask) | (val & mask);
    endfunction

    function automatic bus_op_t rd_op(input logic [31:0] a);
        return '{vld: 1'b1, we: 1'b0, addr: a, data: 32'h0};
    endfunction

    function automatic bus_op_t wr_op(input logic [31:0] a, input logic [31:0] d);
        return '{vld: 1'b1, we: 1'b1, addr: a, data: d};
    endfunction

endpackage

// File: rtl/lbs_reg_master.sv
module lbs_reg_master #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic              op_we,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [31:0]       op_data,
    output logic              op_done,
    output logic [31:0]       rd_val,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [31:0]       bus_wdata,
    input  logic              bus_ack,
    input  logic [31:0]       bus_rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            bus_req   <= 1'b0;
            bus_we    <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
            op_done   <= 1'b0;
            rd_val    <= '0;
        end else begin
            op_done <= 1'b0;
            if (!bus_req && go) begin
                bus_req   <= 1'b1;
                bus_we    <= op_we;
                bus_addr  <= op_addr;
                bus_wdata <= op_data;
            end else if (bus_req && bus_ack) begin
                bus_req <= 1'b0;
                op_done <= 1'b1;
                if (!bus_we) rd_val <= bus_rdata;
            end
        end
    end

    p_req_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) &&
                                   $stable(bus_we) && $stable(bus_wdata)));
endmodule

// File: rtl/lbs_wait_timer.sv
module lbs_wait_timer #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    p_count_down_r8: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/pcie_link_seq.sv
module pcie_link_seq
    import lbs_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int CLK_HZ      = 125_000_000,
    parameter int LINK_TMO_MS = 100,
    parameter int SETTLE_US   = 100,
    parameter int TGT_SPEED   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [31:0]       cfg_base,
    input  logic [31:0]       cfg_size,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [31:0]       bus_wdata,
    input  logic              bus_ack,
    input  logic [31:0]       bus_rdata,
    output logic              done,
    output logic              link_ok,
    output logic [3:0]        link_speed,
    output logic [3:0]        link_width
);
    localparam longint TMO_CYC = longint'(CLK_HZ) * LINK_TMO_MS / 1000;
    localparam longint STL_CYC = longint'(CLK_HZ) * SETTLE_US / 1000000;
    localparam longint MAX_CYC = (TMO_CYC > STL_CYC) ? TMO_CYC : STL_CYC;
    localparam int     TW      = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC + 1);

    step_t       st, st_nxt;
    bus_op_t     op;
    logic        issued, go, op_done, up0, tmr_load, tmr_zero;
    logic [31:0] rd_val;
    logic [TW-1:0] tmr_val;

    // operation issued by each step; writes merge into the last value read
    always_comb begin
        op = '0;
        unique case (st)
            S_CHK0, S_CHK1, S_POLL: op = rd_op(RA_GSTAT);
            S_CTL_RD, S_RUN_RD:     op = rd_op(RA_GCTRL);
            S_HALT:   op = wr_op(RA_GCTRL, rd_val & ~TRAIN_EN);
            S_TYPE:   op = wr_op(RA_GCTRL, merge_field(up0 ? rd_val : (rd_val & ~TRAIN_EN),
                                                       MODE_MASK, MODE_RC));
            S_RCACHE: op = wr_op(RA_RCACHE, RCACHE_VAL);
            S_WCACHE: op = wr_op(RA_WCACHE, WCACHE_VAL);
            S_LC2_RD: op = rd_op(RA_LCTL2);
            S_LC2_WR: op = wr_op(RA_LCTL2, merge_field(rd_val, 32'hF, 32'(TGT_SPEED)));
            S_CAP_RD: op = rd_op(RA_LCAP);
            S_CAP_WR: op = wr_op(RA_LCAP, merge_field(rd_val, 32'hF, 32'(TGT_SPEED)));
            S_EQ_RD:  op = rd_op(RA_EQCTL);
            S_EQ_WR:  op = wr_op(RA_EQCTL, rd_val | EQ_OPT);
            S_RUN_WR: op = wr_op(RA_GCTRL, rd_val | TRAIN_EN);
            S_LSTAT:  op = rd_op(RA_LSTAT);
            S_W_SEL:  op = wr_op(RA_WSEL, 32'h0);
            S_W_BLO:  op = wr_op(RA_WBLO, cfg_base);
            S_W_BHI:  op = wr_op(RA_WBHI, 32'h0);
            S_W_LIM:  op = wr_op(RA_WLIM, cfg_base + cfg_size);
            S_W_TLO:  op = wr_op(RA_WTLO, 32'h0);
            S_W_THI:  op = wr_op(RA_WTHI, 32'h0);
            S_W_CR1:  op = wr_op(RA_WCR1, WIN_CFG0);
            S_W_CR2:  op = wr_op(RA_WCR2, WIN_ON);
            default:  op = '0;
        endcase
    end

    assign go = op.vld && !issued;

    always_comb begin
        st_nxt = st;
        unique case (st)
            S_IDLE, S_OK, S_FAIL: if (start) st_nxt = S_CHK0;
            S_SETTLE: if (tmr_zero) st_nxt = S_LSTAT;
            default: if (op_done) begin
                unique case (st)
                    S_CHK0:   st_nxt = S_CTL_RD;
                    S_CTL_RD: st_nxt = up0 ? S_TYPE : S_HALT;
                    S_HALT:   st_nxt = S_TYPE;
                    S_TYPE:   st_nxt = S_RCACHE;
                    S_RCACHE: st_nxt = S_WCACHE;
                    S_WCACHE: st_nxt = S_LC2_RD;
                    S_LC2_RD: st_nxt = S_LC2_WR;
                    S_LC2_WR: st_nxt = S_CAP_RD;
                    S_CAP_RD: st_nxt = S_CAP_WR;
                    S_CAP_WR: st_nxt = S_EQ_RD;
                    S_EQ_RD:  st_nxt = S_EQ_WR;
                    S_EQ_WR:  st_nxt = S_CHK1;
                    S_CHK1:   st_nxt = link_is_up(rd_val) ? S_POLL : S_RUN_RD;
                    S_RUN_RD: st_nxt = S_RUN_WR;
                    S_RUN_WR: st_nxt = S_POLL;
                    S_POLL:   st_nxt = link_is_up(rd_val) ? S_SETTLE :
                                       (tmr_zero ? S_FAIL : S_POLL);
                    S_LSTAT:  st_nxt = S_W_SEL;
                    S_W_SEL:  st_nxt = S_W_BLO;
                    S_W_BLO:  st_nxt = S_W_BHI;
                    S_W_BHI:  st_nxt = S_W_LIM;
                    S_W_LIM:  st_nxt = S_W_TLO;
                    S_W_TLO:  st_nxt = S_W_THI;
                    S_W_THI:  st_nxt = S_W_CR1;
                    S_W_CR1:  st_nxt = S_W_CR2;
                    S_W_CR2:  st_nxt = S_OK;
                    default:  st_nxt = S_IDLE;
                endcase
            end
        endcase
    end

    assign tmr_load = (st_nxt != st) && (st_nxt == S_POLL || st_nxt == S_SETTLE);
    assign tmr_val  = (st_nxt == S_SETTLE) ? TW'(STL_CYC) : TW'(TMO_CYC);

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= S_IDLE;
            issued     <= 1'b0;
            up0        <= 1'b0;
            done       <= 1'b0;
            link_ok    <= 1'b0;
            link_speed <= '0;
            link_width <= '0;
        end else begin
            st      <= st_nxt;
            issued  <= op_done ? 1'b0 : (go ? 1'b1 : issued);
            done    <= (st_nxt == S_OK) || (st_nxt == S_FAIL);
            link_ok <= (st_nxt == S_OK);
            if (st == S_CHK0 && op_done) up0 <= link_is_up(rd_val);
            if (st == S_LSTAT && op_done) begin
                link_speed <= rd_val[19:16];
                link_width <= rd_val[23:20];
            end
        end
    end

    lbs_reg_master #(.ADDR_W(ADDR_W)) u_master (
        .clk(clk), .rst(rst), .go(go), .op_we(op.we),
        .op_addr(ADDR_W'(op.addr)), .op_data(op.data),
        .op_done(op_done), .rd_val(rd_val),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    lbs_wait_timer #(.W(TW)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
    );

    p_halt_clears_r3: assert property (@(posedge clk) disable iff (rst)
        (st == S_HALT && bus_req) |-> (bus_we && !bus_wdata[2]));
    p_mode_field_r4: assert property (@(posedge clk) disable iff (rst)
        (st == S_TYPE && bus_req) |-> (bus_wdata[7:4] == 4'd4));
    p_cache_vals_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && bus_addr == ADDR_W'(RA_RCACHE)) |-> (bus_wdata == RCACHE_VAL));
    p_fail_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (st == S_FAIL) |-> !bus_req);
    p_settled_r9: assert property (@(posedge clk) disable iff (rst)
        (st == S_LSTAT) |-> tmr_zero);
    p_ok_has_done_r11: assert property (@(posedge clk) disable iff (rst)
        link_ok |-> done);
endmodule

// File: tb/pcie_link_seq_bench.sv
module pcie_link_seq_bench;
    localparam int ADDR_W = 16;
    localparam int CLK_HZ = 100_000;
    localparam int TMO    = 10000;
    localparam int STL    = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [31:0] cfg_base = '0, cfg_size = '0;
    logic bus_req, bus_we, bus_ack, done, link_ok;
    logic [ADDR_W-1:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic [3:0] link_speed, link_width;

    always #4 clk = ~clk;

    pcie_link_seq #(.ADDR_W(ADDR_W), .CLK_HZ(CLK_HZ)) u_pcie_link_seq (
        .clk(clk), .rst(rst), .start(start), .cfg_base(cfg_base), .cfg_size(cfg_size),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .done(done), .link_ok(link_ok),
        .link_speed(link_speed), .link_width(link_width)
    );

    int checks = 0, errors = 0;
    int cyc = 0;

    // register model
    logic [31:0] m_ctrl, m_sts, m_lstat, m_lc2, m_lcap, m_eq;
    int mode = 2;       // 0 trains after enable, 1 always up, 2 fixed status
    int train_cnt = 0;
    logic [31:0] wa [0:63];
    logic [31:0] wd [0:63];
    int nw = 0;
    int first_up = -1, lstat_at = -1;
    logic ack_q = 1'b0, req_q = 1'b0, ack_prev = 1'b0;
    logic [31:0] rdata_q = '0;
    int hs_bad = 0;

    assign bus_ack   = ack_q;
    assign bus_rdata = rdata_q;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        req_q <= bus_req;
        ack_prev <= ack_q;
        if (req_q && !bus_req && !ack_prev) hs_bad <= hs_bad + 1;
        if (bus_req && !ack_q) begin
            ack_q <= 1'b1;
            if (bus_we) begin
                if (nw < 64) begin
                    wa[nw] <= 32'(bus_addr);
                    wd[nw] <= bus_wdata;
                end
                nw <= nw + 1;
                case (32'(bus_addr))
                    32'h8000: m_ctrl <= bus_wdata;
                    32'h00A0: m_lc2  <= bus_wdata;
                    32'h007C: m_lcap <= bus_wdata;
                    32'h08A8: m_eq   <= bus_wdata;
                    default: ;
                endcase
            end else begin
                case (32'(bus_addr))
                    32'h8000: rdata_q <= m_ctrl;
                    32'h8008: rdata_q <= m_sts;
                    32'h0080: rdata_q <= m_lstat;
                    32'h00A0: rdata_q <= m_lc2;
                    32'h007C: rdata_q <= m_lcap;
                    32'h08A8: rdata_q <= m_eq;
                    default:  rdata_q <= 32'h0;
                endcase
                if (32'(bus_addr) == 32'h8008 && m_sts[1] && m_sts[9] && first_up < 0)
                    first_up <= cyc;
                if (32'(bus_addr) == 32'h0080) lstat_at <= cyc;
            end
        end else begin
            ack_q <= 1'b0;
        end
        if (mode == 0) begin
            if (m_ctrl[2]) begin
                train_cnt <= train_cnt + 1;
                if (train_cnt == 40) m_sts <= 32'h0000_0202;
            end else begin
                train_cnt <= 0;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_wr(input int i, input logic [31:0] a, input logic [31:0] d,
                          input string tag);
        chk(wa[i] == a, tag, wa[i], a);
        chk(wd[i] == d, tag, wd[i], d);
    endtask

    task automatic setup(input int md, input logic [31:0] ctrl, input logic [31:0] sts,
                         input logic [31:0] lst);
        @(negedge clk);
        mode = md; m_ctrl = ctrl; m_sts = sts; m_lstat = lst;
        m_lc2 = 32'hABCD_0051; m_lcap = 32'h0040_F012; m_eq = 32'h0000_0100;
        train_cnt = 0; nw = 0; first_up = -1; lstat_at = -1;
    endtask

    task automatic run(output int cycles);
        int t0;
        @(negedge clk); start = 1'b1; t0 = cyc;
        @(negedge clk); start = 1'b0;
        while (!done) @(negedge clk);
        cycles = cyc - t0;
    endtask

    task automatic t_reset;
        chk(!done && !link_ok && !bus_req, "R1 flags after reset", {done, link_ok, bus_req}, 0);
        chk(link_speed == 0 && link_width == 0, "R1 captures after reset",
            {link_speed, link_width}, 0);
    endtask

    task automatic t_cold;
        int c;
        setup(0, 32'h0000_1F0F, 32'h0, 32'h0023_0000);
        cfg_base = 32'hE000_0000; cfg_size = 32'h0010_0000;
        run(c);
        chk(link_ok, "R11 cold ok", link_ok, 1);
        chk(link_speed == 3 && link_width == 2, "R11 speed/width", {link_speed, link_width}, 32'h32);
        chk(nw == 16, "R7 cold write count", nw, 16);
        chk_wr(0, 32'h8000, 32'h0000_1F0B, "R3 halt first");
        chk_wr(1, 32'h8000, 32'h0000_1F4B, "R4 mode field");
        chk_wr(2, 32'h8050, 32'h3511, "R5 read cache");
        chk_wr(3, 32'h8054, 32'h5311, "R5 write cache");
        chk_wr(4, 32'h00A0, 32'hABCD_0053, "R6 link ctl2");
        chk_wr(5, 32'h007C, 32'h0040_F013, "R6 link cap");
        chk_wr(6, 32'h08A8, 32'h0000_0120, "R6 eq ctl");
        chk_wr(7, 32'h8000, 32'h0000_1F4F, "R7 restart training");
        chk_wr(8, 32'h0900, 32'h0, "R10 select");
        chk_wr(9, 32'h090C, 32'hE000_0000, "R10 base lo");
        chk_wr(10, 32'h0910, 32'h0, "R10 base hi");
        chk_wr(11, 32'h0914, 32'hE010_0000, "R10 limit");
        chk_wr(12, 32'h0918, 32'h0, "R10 target lo");
        chk_wr(13, 32'h091C, 32'h0, "R10 target hi");
        chk_wr(14, 32'h0904, 32'h4, "R10 cfg type");
        chk_wr(15, 32'h0908, 32'h8000_0000, "R10 enable last");
        chk(first_up >= 0 && lstat_at - first_up >= STL, "R9 settle gap",
            lstat_at - first_up, STL);
    endtask

    task automatic t_warm;
        int c;
        setup(1, 32'h0000_0034, 32'h0000_0202, 32'h0014_0000);
        cfg_base = 32'h4000_0000; cfg_size = 32'h0800_0000;
        run(c);
        chk(link_ok && done, "R11 warm ok", {done, link_ok}, 3);
        chk(link_speed == 4 && link_width == 1, "R11 warm speed/width",
            {link_speed, link_width}, 32'h14);
        chk(nw == 14, "R7 no restart when up", nw, 14);
        chk_wr(0, 32'h8000, 32'h0000_0044, "R3 bit2 kept when up");
        chk_wr(9, 32'h0914, 32'h4800_0000, "R10 warm limit");
        chk_wr(13, 32'h0908, 32'h8000_0000, "R10 warm enable");
    endtask

    task automatic t_stuck(input logic [31:0] sts, input string tag);
        int c, winw;
        setup(2, 32'h0, sts, 32'h00FF_0000);
        run(c);
        chk(done && !link_ok, {tag, " fails"}, {done, link_ok}, 2);
        chk(c >= TMO, "R8 waited full timeout", c, TMO);
        winw = 0;
        for (int i = 0; i < nw && i < 64; i++)
            if (wa[i] >= 32'h0900 && wa[i] <= 32'h091C) winw++;
        chk(winw == 0, "R8 no window writes", winw, 0);
        chk(nw == 8, "R8 write count", nw, 8);
        chk(link_speed == 4 && link_width == 1, "R11 captures held on fail",
            {link_speed, link_width}, 32'h14);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst = 1'b0;
        repeat (2) @(negedge clk);
        t_reset();
        t_cold();
        t_warm();
        t_stuck(32'h0000_0200, "R2 only phy bit");
        t_stuck(32'h0000_0002, "R2 only dll bit");
        chk(hs_bad == 0, "R12 request held to ack", hs_bad, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule